// File: doc/BRIEF.md
# Dual-Output Single Pulse Timer

This block makes one shot of two related pulses from an up-counter and two compare registers. A run bit starts the shot. Software sets it with a one-cycle request, or a rising edge on an asynchronous trigger pin sets it. When the run bit goes high, the counter restarts at zero and output A goes high. Output B goes high later, when the count reaches compare B. A match on compare A clears the run bit, and both outputs fall together. Software can also end the shot early with a clear request.

Output A is therefore as wide as the compare-A value, and output B is as wide as compare A minus compare B. Each comparator sets its own sticky interrupt flag. When the run bit drops, the counter keeps its value. The counter is cleared only by the next start. A compare register is written through a small port: a select bit picks the register and a write strobe loads the data.

Top module: `dpt_top`

## Requirements
- R1: After reset, out_a, out_b, running, irq_a and irq_b are low, count is zero, and both compare registers hold zero.
- R2: While idle, a start (run_set high, or a detected trigger edge) sets running and out_a and zeroes count at the next clock edge.
- R3: trig_in passes through two synchronising flip-flops and an edge detector. When the block is idle, a low-to-high change on trig_in that is stable before clock edge k sets running at edge k+2. A trigger edge that is detected while running is high is ignored.
- R4: While running is high, count increases by one at each clock edge, wrapping at 2^10. While running is low and no start is requested, count holds its value.
- R5: When the next count equals compare A, running and out_a clear at that edge and irq_a sets. out_a is therefore high for exactly compare-A cycles, and a compare-A value of zero gives 1024 cycles.
- R6: When compare B is less than compare A, out_b rises at the edge where count becomes compare B, or together with the start when compare B is zero. out_b falls together with out_a, so it is high for compare A minus compare B cycles. irq_b sets when out_b rises.
- R7: A run_clr pulse while running clears running, out_a and out_b at the next edge. After that the count is held until the next start.
- R8: irq_a and irq_b stay set until a one-cycle irq_clr, where bit 0 clears irq_a and bit 1 clears irq_b. A new match in the same cycle as a clear wins over the clear.
- R9: When compare B is greater than or equal to compare A, out_b stays low for the whole shot and irq_b is not set by that shot.
- R10: When cmp_we is high, cmp_wdata loads compare A if cmp_sel is 0 and compare B if cmp_sel is 1. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_set | input | 1 | Software start request, one cycle |
| run_clr | input | 1 | Software stop request, one cycle |
| trig_in | input | 1 | Asynchronous external start trigger |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_sel | input | 1 | Compare register select, 0 = A, 1 = B |
| cmp_wdata | input | 10 | Compare register write data |
| irq_clr | input | 2 | Flag clear, bit 0 for A, bit 1 for B |
| running | output | 1 | Run bit |
| count | output | 10 | Counter value |
| out_a | output | 1 | Pulse output A |
| out_b | output | 1 | Pulse output B |
| irq_a | output | 1 | Compare-A interrupt flag |
| irq_b | output | 1 | Compare-B interrupt flag |

## Verification
The assertions assume the following about the inputs. run_set, run_clr, cmp_we and irq_clr are synchronous to clk. Only trig_in may change at any time. The compare values are taken to be whatever the registers held in the cycle before a decision, so the checks allow writes in the middle of a shot. The stimulus changes all synchronous inputs just after the falling edge. It keeps random compare-A values small, so that shots end well inside the run. It toggles trig_in at random, including while a shot is running, and issues clear requests at random so that they land both inside and outside shots.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    localparam int unsigned DPT_CNT_W   = 10;
    localparam int unsigned DPT_SYNC_N  = 2;
    localparam int unsigned DPT_NUM_CMP = 2;
    localparam int unsigned DPT_IDX_A   = 0;
    localparam int unsigned DPT_IDX_B   = 1;
endpackage

// File: rtl/dpt_trig_sync.sv
module dpt_trig_sync #(
    parameter int unsigned STAGES = dpt_pkg::DPT_SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], trig_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign trig_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R3: a detected edge lasts exactly one cycle
    a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);
endmodule

// File: rtl/dpt_cmp_regs.sv
module dpt_cmp_regs #(
    parameter int unsigned CNT_W = dpt_pkg::DPT_CNT_W,
    parameter int unsigned NUM   = dpt_pkg::DPT_NUM_CMP,
    localparam int unsigned SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [CNT_W-1:0]           wdata,
    output logic [NUM-1:0][CNT_W-1:0]  value
);
    logic [NUM-1:0][CNT_W-1:0] val_d, val_q;

    for (genvar i = 0; i < NUM; i++) begin : g_reg
        always_comb begin
            val_d[i] = val_q[i];
            if (we && (sel == SEL_W'(i))) val_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q[i] <= '0;
            else        val_q[i] <= val_d[i];
        end

        // R10: a register moves only when written through its own select
        a_r10_write_only: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == SEL_W'(i)) |=> $stable(val_q[i]));
    end

    assign value = val_q;
endmodule

// File: rtl/dpt_irq_flags.sv
module dpt_irq_flags #(
    parameter int unsigned NUM = dpt_pkg::DPT_NUM_CMP
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] hit,
    input  logic [NUM-1:0] clr,
    output logic [NUM-1:0] flag
);
    logic [NUM-1:0] flag_d, flag_q;

    for (genvar i = 0; i < NUM; i++) begin : g_flag
        always_comb begin
            flag_d[i] = hit[i] | (flag_q[i] & ~clr[i]);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= flag_d[i];
        end

        // R8: sticky until cleared
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i]) |=> flag_q[i]);
        // R8: a match always lands in the flag
        a_r8_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag_q[i]);
    end

    assign flag = flag_q;
endmodule

// File: rtl/dpt_core.sv
module dpt_core #(
    parameter int unsigned CNT_W = dpt_pkg::DPT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             out_a,
    output logic             out_b,
    output logic             hit_a,
    output logic             hit_b
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             pa;
        logic             pb;
        logic             b_seen;
    } core_t;

    core_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             b_allowed;

    always_comb begin
        st_d      = st_q;
        hit_a     = 1'b0;
        hit_b     = 1'b0;
        cnt_inc   = st_q.cnt + CNT_W'(1);
        b_allowed = (cmp_b < cmp_a);
        if (!st_q.run) begin
            if (start_req) begin
                st_d.run    = 1'b1;
                st_d.cnt    = '0;
                st_d.pa     = 1'b1;
                st_d.pb     = b_allowed && (cmp_b == '0);
                st_d.b_seen = st_d.pb;
                hit_b       = st_d.pb;
            end
        end else begin
            st_d.cnt = cnt_inc;
            hit_a    = (cnt_inc == cmp_a);
            if (hit_a || stop_req) begin
                st_d.run = 1'b0;
                st_d.pa  = 1'b0;
                st_d.pb  = 1'b0;
            end else if (!st_q.b_seen && b_allowed && (cnt_inc == cmp_b)) begin
                st_d.pb     = 1'b1;
                st_d.b_seen = 1'b1;
                hit_b       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;
    assign count   = st_q.cnt;
    assign out_a   = st_q.pa;
    assign out_b   = st_q.pb;

    // R2: a new shot begins at zero with output A high
    a_r2_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (out_a && count == '0));
    // R4: one step per running cycle
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (count == CNT_W'($past(count) + CNT_W'(1))));
    // R4: idle count holds when no start is asked for
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_req) |=> $stable(count));
    // R5, R7: end of a shot drops both outputs
    a_r5_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (!out_a && !out_b));
    // R6: output B lives inside output A
    a_r6_b_within_a: assert property (@(posedge clk) disable iff (!rst_n)
        out_b |-> out_a);
    // R9: output B rises only when compare B was below compare A
    a_r9_b_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_b) |-> ($past(cmp_b) < $past(cmp_a)));
endmodule

// File: rtl/dpt_top.sv
module dpt_top #(
    parameter int unsigned CNT_W = dpt_pkg::DPT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_set,
    input  logic             run_clr,
    input  logic             trig_in,
    input  logic             cmp_we,
    input  logic             cmp_sel,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       irq_clr,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             out_a,
    output logic             out_b,
    output logic             irq_a,
    output logic             irq_b
);
    import dpt_pkg::*;

    logic                              trig_rise;
    logic [DPT_NUM_CMP-1:0][CNT_W-1:0] cmp_val;
    logic                              hit_a, hit_b;
    logic [DPT_NUM_CMP-1:0]            flags;
    logic                              start_req;

    dpt_trig_sync #(.STAGES(DPT_SYNC_N)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .trig_rise  (trig_rise)
    );

    dpt_cmp_regs #(.CNT_W(CNT_W), .NUM(DPT_NUM_CMP)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmp_we),
        .sel   (cmp_sel),
        .wdata (cmp_wdata),
        .value (cmp_val)
    );

    assign start_req = run_set | trig_rise;

    dpt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (run_clr),
        .cmp_a     (cmp_val[DPT_IDX_A]),
        .cmp_b     (cmp_val[DPT_IDX_B]),
        .running   (running),
        .count     (count),
        .out_a     (out_a),
        .out_b     (out_b),
        .hit_a     (hit_a),
        .hit_b     (hit_b)
    );

    dpt_irq_flags #(.NUM(DPT_NUM_CMP)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   ({hit_b, hit_a}),
        .clr   (irq_clr),
        .flag  (flags)
    );

    assign irq_a = flags[DPT_IDX_A];
    assign irq_b = flags[DPT_IDX_B];

    // R3: a trigger edge during a shot leaves the run bit set
    a_r3_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (running && trig_rise && !run_clr && !hit_a) |=> running);
endmodule

// File: tb/sim_dpt_top.sv
module sim_dpt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_set = 1'b0, run_clr = 1'b0, trig_in = 1'b0;
    logic       cmp_we = 1'b0, cmp_sel = 1'b0;
    logic [9:0] cmp_wdata = '0;
    logic [1:0] irq_clr = '0;
    logic       running, out_a, out_b, irq_a, irq_b;
    logic [9:0] count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dpt_top u0 (
        .clk(clk), .rst_n(rst_n), .run_set(run_set), .run_clr(run_clr),
        .trig_in(trig_in), .cmp_we(cmp_we), .cmp_sel(cmp_sel),
        .cmp_wdata(cmp_wdata), .irq_clr(irq_clr), .running(running),
        .count(count), .out_a(out_a), .out_b(out_b), .irq_a(irq_a), .irq_b(irq_b)
    );

    // reference state built from the requirements
    logic       m_s1, m_s2, m_s3, m_run, m_oa, m_ob, m_bd, m_ia, m_ib;
    logic [9:0] m_cnt, m_ca, m_cb;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_run <= 0; m_oa <= 0; m_ob <= 0;
            m_bd <= 0; m_ia <= 0; m_ib <= 0; m_cnt <= '0; m_ca <= '0; m_cb <= '0;
        end else begin
            logic       rise, ha, hb, run_n, oa_n, ob_n, bd_n, b_ok;
            logic [9:0] nx, cnt_n;
            rise = m_s2 & ~m_s3;
            b_ok = m_cb < m_ca;
            ha = 0; hb = 0;
            run_n = m_run; oa_n = m_oa; ob_n = m_ob; bd_n = m_bd; cnt_n = m_cnt;
            nx = m_cnt + 10'd1;
            if (!m_run) begin
                if (run_set || rise) begin
                    run_n = 1; cnt_n = '0; oa_n = 1;
                    ob_n = b_ok && (m_cb == 0); bd_n = ob_n; hb = ob_n;
                end
            end else begin
                cnt_n = nx;
                ha = (nx == m_ca);
                if (ha || run_clr) begin
                    run_n = 0; oa_n = 0; ob_n = 0;
                end else if (!m_bd && b_ok && nx == m_cb) begin
                    ob_n = 1; bd_n = 1; hb = 1;
                end
            end
            m_s1 <= trig_in; m_s2 <= m_s1; m_s3 <= m_s2;
            m_run <= run_n; m_oa <= oa_n; m_ob <= ob_n; m_bd <= bd_n; m_cnt <= cnt_n;
            m_ia <= ha | (m_ia & ~irq_clr[0]);
            m_ib <= hb | (m_ib & ~irq_clr[1]);
            if (cmp_we && !cmp_sel) m_ca <= cmp_wdata;
            if (cmp_we &&  cmp_sel) m_cb <= cmp_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 running", running, m_run);
        chk("R5 out_a", out_a, m_oa);
        chk("R6 out_b", out_b, m_ob);
        chk("R4 count", count, m_cnt);
        chk("R8 irq_a", irq_a, m_ia);
        chk("R8 irq_b", irq_b, m_ib);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        check_all();
        run_set = 0; run_clr = 0; cmp_we = 0; irq_clr = '0;
    endtask

    task automatic wr(input logic sel, input int val);
        cmp_we = 1; cmp_sel = sel; cmp_wdata = 10'(val);
        tick();
    endtask

    task automatic shot(input int ea, input int eb, input string tag);
        int wa = 0, wb = 0;
        run_set = 1;
        tick();
        while (out_a && wa < 2000) begin
            wa++;
            if (out_b) wb++;
            tick();
        end
        chk({tag, " out_a width"}, wa, ea);
        chk({tag, " out_b width"}, wb, eb);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int held;
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 running", running, 0); chk("R1 out_a", out_a, 0);
        chk("R1 out_b", out_b, 0); chk("R1 count", count, 0);
        chk("R1 irq", {irq_b, irq_a}, 0);
        rst_n = 1;
        tick();

        // R10, R5, R6: A=10, B=4 gives widths 10 and 6
        wr(0, 10); wr(1, 4);
        shot(10, 6, "R5 R6 basic");
        chk("R8 both flags", {irq_b, irq_a}, 3);
        chk("R7 count held after end", count, 10);
        repeat (3) tick();
        chk("R4 count still held", count, 10);
        irq_clr = 2'b01; tick();
        chk("R8 clear A only", {irq_b, irq_a}, 2);
        irq_clr = 2'b10; tick();
        chk("R8 clear B", {irq_b, irq_a}, 0);

        // R6: B=0 rises with start
        wr(1, 0);
        shot(10, 10, "R6 B zero");

        // R9: B equal to A and B above A
        wr(1, 10); irq_clr = 2'b11; tick();
        shot(10, 0, "R9 B equal");
        chk("R9 no irq_b", irq_b, 0);
        wr(1, 200);
        shot(10, 0, "R9 B above");
        chk("R9 no irq_b again", irq_b, 0);

        // R3: trigger latency, ignored while running
        wr(0, 30); wr(1, 3);
        trig_in = 1;
        tick(); chk("R3 not yet 1", running, 0);
        tick(); chk("R3 not yet 2", running, 0);
        tick(); chk("R3 started", running, 1);
        chk("R3 count zero", count, 0);
        repeat (3) tick();
        trig_in = 0; repeat (3) tick();
        trig_in = 1; repeat (3) tick();
        chk("R3 still running", running, 1);
        while (running) tick();
        chk("R5 stop at A", count, 30);
        repeat (5) tick();
        chk("R3 no restart", running, 0);
        trig_in = 0; tick();

        // R7: software clear holds count, restart zeroes it
        wr(0, 50);
        run_set = 1; tick();
        repeat (7) tick();
        run_clr = 1; tick();
        chk("R7 stopped", running, 0);
        chk("R7 outputs low", {out_b, out_a}, 0);
        held = count;
        chk("R7 count value", held, 8);
        repeat (4) tick();
        chk("R7 count held", count, held);
        run_set = 1; tick();
        chk("R2 restart zero", count, 0);
        run_clr = 1; tick();

        // R5: zero compare A gives 1024 cycles
        wr(0, 0); wr(1, 5);
        shot(1024, 0, "R5 A zero");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4) begin
                cmp_we = 1; cmp_sel = 0; cmp_wdata = 10'($urandom_range(1, 60));
            end else if (r < 8) begin
                cmp_we = 1; cmp_sel = 1; cmp_wdata = 10'($urandom_range(0, 70));
            end
            if ($urandom_range(0, 99) < 6) run_set = 1;
            if ($urandom_range(0, 99) < 2) run_clr = 1;
            if ($urandom_range(0, 99) < 5) trig_in = ~trig_in;
            if ($urandom_range(0, 99) < 5) irq_clr = 2'($urandom_range(1, 3));
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule